// File: doc/BRIEF.md
# Early-Terminating Sequential Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns the low 32 bits of the product. The multiplier operand is consumed one byte per cycle, least significant byte first. Each byte's partial product, shifted into place, is added into an accumulator. The number of cycles depends on the multiplier. When its upper bytes only repeat its sign (all zeros or all ones), the remaining bytes carry no information and the operation stops early.

A client raises a start strobe with both operands while the block is idle. Busy then stays high for the working cycles. A one-cycle done pulse marks a valid result. Along with done, the block reports how many working cycles it spent. The result and the count stay on the outputs until the next completion.

Top module: `early_term_mult`

## Requirements
- R1: While reset is asserted, and after it is released, busy_o, done_o, product_o and cycles_o are all zero, including when reset interrupts an operation in progress.
- R2: product_o equals the low 32 bits of mcand_i times mplier_i, for both unsigned and two's-complement operands.
- R3: When mplier_i bits 31:8 are all zeros or all ones, busy_o is high for exactly 1 cycle after the accepting edge and done_o rises on the edge that ends that cycle.
- R4: Otherwise, when bits 31:16 are all zeros or all ones, the operation takes exactly 2 cycles.
- R5: Otherwise, when bits 31:24 are all zeros or all ones, the operation takes exactly 3 cycles.
- R6: In every other case the operation takes exactly 4 cycles.
- R7: An early finish with an all-ones upper part still yields the correct two's-complement product, even when the top bit of the last consumed byte is 0 (for example, multiplier 0xFFFFFF05).
- R8: done_o is high for exactly one cycle per operation. product_o and cycles_o hold their values after done_o falls.
- R9: A start_i pulse while busy_o is high is ignored. The running operation's result and latency are unchanged, and no second operation follows.
- R10: When done_o is high, cycles_o (1 to 4) equals the number of cycles busy_o was high for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier, which sets the latency |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| product_o | output | 32 | Low 32 bits of the product |
| cycles_o | output | 3 | Working cycles used by the last operation |

## Verification
The multiplier values are chosen so that each one lands on a particular latency class, and each class is reached through both all-zero and all-ones upper parts. These patterns separate the four exit points and show whether the span detector lets the smallest uniform span win. Multipliers such as 0xFFFFFF05 and 0xFFFF00FF put a clear top bit in the last consumed byte under an all-ones upper part. A design that only sign-extends that byte fails on them. Patterns with the most negative operands and zeros exercise wrap-around of the low 32 bits. Directed cases cover a start pulse during a long operation and reset in the middle of an operation.

// File: rtl/etm_pkg.sv
package etm_pkg;

   typedef enum logic {
      ETM_IDLE = 1'b0,
      ETM_RUN  = 1'b1
   } etm_state_e;

   function automatic int unsigned etm_chunks(input int unsigned width, input int unsigned chunk);
      return width / chunk;
   endfunction

endpackage

// File: rtl/etm_span_detect.sv
module etm_span_detect #(
   parameter  int unsigned WIDTH  = 32,
   parameter  int unsigned CHUNK  = 8,
   localparam int unsigned NCHUNK = WIDTH / CHUNK,
   localparam int unsigned CNT_W  = $clog2(NCHUNK + 1)
) (
   input  logic [WIDTH-1:CHUNK] upper_i,
   output logic [CNT_W-1:0]     need_o,
   output logic                 ext_o
);

   // uniform[k]: bits WIDTH-1 .. k*CHUNK are all equal
   logic [NCHUNK-1:1] uniform;

   for (genvar k = 1; k < NCHUNK; k++) begin : g_span
      localparam int unsigned LO = k * CHUNK;
      assign uniform[k] = (&upper_i[WIDTH-1:LO]) | ~(|upper_i[WIDTH-1:LO]);
   end

   // smallest uniform span wins
   always_comb begin
      need_o = CNT_W'(NCHUNK);
      for (int k = NCHUNK - 1; k >= 1; k--) begin
         if (uniform[k]) need_o = CNT_W'(k);
      end
   end

   // an early finish over an all-ones upper part weights the last byte negatively
   assign ext_o = upper_i[WIDTH-1] & (need_o != CNT_W'(NCHUNK));

endmodule

// File: rtl/etm_chunk_mac.sv
module etm_chunk_mac #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned CHUNK = 8,
   parameter int unsigned IDX_W = 2
) (
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [CHUNK-1:0] chunk_i,
   input  logic             ext_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [WIDTH-1:0] acc_o
);

   localparam int unsigned SH_W = $clog2(WIDTH);

   logic [WIDTH-1:0] digit;
   logic [WIDTH-1:0] partial;
   logic [SH_W-1:0]  shamt;

   // digit value is chunk, or chunk - 2^CHUNK when ext_i is set
   assign digit   = {{(WIDTH - CHUNK){ext_i}}, chunk_i};
   assign partial = mcand_i * digit;
   assign shamt   = SH_W'(idx_i * CHUNK);
   assign acc_o   = acc_i + (partial << shamt);

endmodule

// File: rtl/early_term_mult.sv
module early_term_mult #(
   parameter  int unsigned WIDTH  = 32,
   parameter  int unsigned CHUNK  = 8,
   localparam int unsigned NCHUNK = WIDTH / CHUNK,
   localparam int unsigned CNT_W  = $clog2(NCHUNK + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] product_o,
   output logic [CNT_W-1:0] cycles_o
);

   import etm_pkg::*;

   localparam int unsigned IDX_W = $clog2(NCHUNK);

   if (CHUNK == 0 || WIDTH % CHUNK != 0) begin : g_bad_split
      $error("early_term_mult: WIDTH must be a multiple of CHUNK");
   end
   if (etm_chunks(WIDTH, CHUNK) < 2) begin : g_bad_count
      $error("early_term_mult: at least two chunks are required");
   end

   etm_state_e       state_q;
   logic [WIDTH-1:0] mcand_q, mplier_q, acc_q, acc_next, product_q;
   logic [CNT_W-1:0] need_q, cycles_q, need_d;
   logic [IDX_W-1:0] idx_q;
   logic             ext_q, ext_d, done_q, last;

   etm_span_detect #(.WIDTH(WIDTH), .CHUNK(CHUNK)) i_span (
      .upper_i (mplier_i[WIDTH-1:CHUNK]),
      .need_o  (need_d),
      .ext_o   (ext_d)
   );

   assign last = (CNT_W'(idx_q) + CNT_W'(1)) == need_q;

   etm_chunk_mac #(.WIDTH(WIDTH), .CHUNK(CHUNK), .IDX_W(IDX_W)) i_mac (
      .acc_i   (acc_q),
      .mcand_i (mcand_q),
      .chunk_i (mplier_q[CHUNK-1:0]),
      .ext_i   (ext_q & last),
      .idx_i   (idx_q),
      .acc_o   (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ETM_IDLE;
         mcand_q   <= '0;
         mplier_q  <= '0;
         acc_q     <= '0;
         need_q    <= '0;
         ext_q     <= 1'b0;
         idx_q     <= '0;
         product_q <= '0;
         cycles_q  <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ETM_IDLE: begin
               if (start_i) begin
                  mcand_q  <= mcand_i;
                  mplier_q <= mplier_i;
                  need_q   <= need_d;
                  ext_q    <= ext_d;
                  idx_q    <= '0;
                  acc_q    <= '0;
                  state_q  <= ETM_RUN;
               end
            end
            ETM_RUN: begin
               acc_q    <= acc_next;
               mplier_q <= mplier_q >> CHUNK;
               idx_q    <= idx_q + IDX_W'(1);
               if (last) begin
                  state_q   <= ETM_IDLE;
                  product_q <= acc_next;
                  cycles_q  <= need_q;
                  done_q    <= 1'b1;
               end
            end
            default: state_q <= ETM_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q == ETM_RUN);
   assign done_o    = done_q;
   assign product_o = product_q;
   assign cycles_o  = cycles_q;

   // ---------------- checker state and assertions ----------------
   logic [CNT_W-1:0] run_cnt;
   logic [WIDTH-1:0] mplier_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt    <= '0;
         mplier_ref <= '0;
      end else begin
         run_cnt <= busy_o ? run_cnt + CNT_W'(1) : '0;
         if (!busy_o && start_i) mplier_ref <= mplier_i;
      end
   end

   assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> product_o == mcand_q * mplier_ref);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_hold_operand_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mcand_q));

   assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_count_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cycles_o == run_cnt) && (cycles_o >= CNT_W'(1)) && (cycles_o <= CNT_W'(NCHUNK)));

endmodule

// File: tb/test_early_term_mult.sv
module test_early_term_mult;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  n;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0007, 32'h0000_0006, 3'd1},
      '{32'h1234_5678, 32'hFFFF_FFFF, 3'd1},
      '{32'h0000_0003, 32'hFFFF_FF05, 3'd1},
      '{32'hABCD_0123, 32'h0000_0000, 3'd1},
      '{32'h0000_1001, 32'h0000_1234, 3'd2},
      '{32'h0000_0005, 32'hFFFF_8001, 3'd2},
      '{32'h7654_3210, 32'hFFFF_00FF, 3'd2},
      '{32'hDEAD_BEEF, 32'h00AB_CDEF, 3'd3},
      '{32'h0000_0009, 32'hFF12_3456, 3'd3},
      '{32'h0000_0011, 32'h00FF_0000, 3'd3},
      '{32'h8000_0000, 32'h1234_5678, 3'd4},
      '{32'hFFFF_FFFF, 32'h8000_0000, 3'd4},
      '{32'hCAFE_F00D, 32'h7F00_0001, 3'd4},
      '{32'h8000_0000, 32'hFFFF_FFFF, 3'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] mcand_i = '0;
   logic [31:0] mplier_i = '0;
   logic        busy_o, done_o;
   logic [31:0] product_o;
   logic [2:0]  cycles_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   early_term_mult i_early_term_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mcand_i   (mcand_i),
      .mplier_i  (mplier_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .product_o (product_o),
      .cycles_o  (cycles_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic string lat_tag(input int n);
      case (n)
         1: return "R3 latency";
         2: return "R4 latency";
         3: return "R5 latency";
         default: return "R6 latency";
      endcase
   endfunction

   // waits from the negedge after acceptance until done; returns busy cycles seen
   task automatic wait_done(output int cnt);
      cnt = 0;
      while (!done_o && cnt < 20) begin
         if (busy_o) cnt++;
         @(negedge clk);
      end
   endtask

   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int n);
      int          cnt;
      logic [31:0] exp_p;
      exp_p = a * b;
      @(negedge clk);
      start_i  = 1'b1;
      mcand_i  = a;
      mplier_i = b;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(cnt);
      check(cnt == n, lat_tag(n), 32'(cnt), 32'(n));
      check(product_o == exp_p, (b[31] && n < 4) ? "R7 product" : "R2 product", product_o, exp_p);
      check(cycles_o == 3'(n), "R10 cycles_o", 32'(cycles_o), 32'(n));
      @(negedge clk);
      check(!done_o, "R8 done width", 32'(done_o), 32'd0);
      check(product_o == exp_p && cycles_o == 3'(n), "R8 hold", product_o, exp_p);
   endtask

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && product_o == '0 && cycles_o == '0, "R1 in reset",
            {busy_o, done_o, cycles_o, product_o[26:0]}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && product_o == '0 && cycles_o == '0, "R1 after reset",
            {busy_o, done_o, cycles_o, product_o[26:0]}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run_op(VECS[i].a, VECS[i].b, int'(VECS[i].n));
      end

      // R9: start while busy is ignored
      @(negedge clk);
      start_i = 1'b1; mcand_i = 32'h1111_1111; mplier_i = 32'h7F00_0001;
      @(negedge clk);
      mcand_i = 32'h0000_0002; mplier_i = 32'h0000_0003;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(cnt);
      cnt = cnt + 1; // first busy cycle elapsed before wait_done began
      check(cnt == 4, "R9 latency", 32'(cnt), 32'd4);
      check(product_o == 32'h1111_1111 * 32'h7F00_0001, "R9 product", product_o,
            32'h1111_1111 * 32'h7F00_0001);
      @(negedge clk);
      @(negedge clk);
      check(!busy_o && !done_o, "R9 no second op", 32'(busy_o), 32'd0);

      // R1: reset in the middle of an operation
      @(negedge clk);
      start_i = 1'b1; mcand_i = 32'h0000_0123; mplier_i = 32'h4000_0000;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!busy_o && !done_o && product_o == '0 && cycles_o == '0, "R1 mid-op reset",
            {busy_o, done_o, cycles_o, product_o[26:0]}, 32'd0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(!done_o && !busy_o, "R1 stays idle", 32'(done_o), 32'd0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog all-requirements act=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule